// File: doc/BRIEF.md
# Dual-Mode Seven-Segment Display Driver

This block drives a bank of four multiplexed seven-segment digits through one shared, active-low segment bus and one active-low digit-enable bus. A status input selects what the bank shows. With the status input low, a 4-bit binary value is turned into its hexadecimal glyph and shown on the leftmost digit, and the other three digits stay dark. With the status input high, the block steps through all four digits and spells the fixed word "FAIL" across them.

A parameterised divider makes a one-cycle scan tick. Every change on the outputs happens on that tick, and the segment pattern and the digit enable always change in the same cycle. Both display modes feed one registered output stage, so each physical output has exactly one driver. Mode changes and new input values take effect at the next tick.

Top module: `seg_dual_display`

## Requirements
- R1: While the synchronous active-high reset is asserted, and after its release until the first scan tick, the segment output is 7'b1111111 and the digit-enable output is 4'b1111.
- R2: A scan tick comes once every TICK_DIV clock cycles. Counting rising edges after reset release from 1, the first tick edge is edge TICK_DIV. Both outputs change only on tick edges.
- R3: When the status input is low at a tick, the digit-enable output becomes 4'b0111, which selects the leftmost digit only.
- R4: When the status input is low at a tick, the segment output becomes the active-low glyph of the 4-bit input, with bit 6 = g and bit 0 = a. The glyphs for 0 to F are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000, 0010000, 0001000, 0000011, 1000110, 0100001, 0000110, 0001110.
- R5: In fail mode, the segment output shows F=7'b0001110 on the leftmost digit, A=7'b0001000 on the mid-left digit, I=7'b1111001 on the mid-right digit and L=7'b1000111 on the rightmost digit.
- R6: On successive fail-mode ticks the digit enable steps through 4'b0111, 4'b1011, 4'b1101, 4'b1110 and then wraps to 4'b0111.
- R7: The first fail-mode tick after any normal-mode tick, or after reset, shows the leftmost digit (F on 4'b0111). The status input and the value are sampled only at ticks.
- R8: After the first tick, exactly one bit of the digit-enable output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| failFlag | input | 1 | Mode select: 1 = show "FAIL", 0 = show the hex value |
| binIn | input | 4 | Value shown in normal mode |
| segOut | output | 7 | Active-low segments, bit 6 = g to bit 0 = a |
| digitEnN | output | 4 | Active-low digit enables, bit 3 = leftmost digit |

## Verification
A wrong scan index shows up at the next fail-mode tick, as a letter on the wrong enable or as a skipped or repeated position in the wrap order. A stale mode or value register shows up one tick period late, as a hex glyph while the status input is high or the reverse. A divider that is off by one moves every update by a cycle, and a sample taken just after the expected tick edge catches it on the first tick.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int DIGITS = 4;
  localparam int SEL_W  = $clog2(DIGITS);

  typedef logic [6:0] segVec_t;

  typedef struct packed {
    logic             load;
    logic             failMode;
    logic [SEL_W-1:0] digitSel;
  } dispStrobe_t;

  localparam segVec_t SEG_BLANK = 7'b1111111;

  function automatic segVec_t hexGlyph(input logic [3:0] v);
    segVec_t g;
    case (v)
      4'h0: g = 7'b1000000;
      4'h1: g = 7'b1111001;
      4'h2: g = 7'b0100100;
      4'h3: g = 7'b0110000;
      4'h4: g = 7'b0011001;
      4'h5: g = 7'b0010010;
      4'h6: g = 7'b0000010;
      4'h7: g = 7'b1111000;
      4'h8: g = 7'b0000000;
      4'h9: g = 7'b0010000;
      4'hA: g = 7'b0001000;
      4'hB: g = 7'b0000011;
      4'hC: g = 7'b1000110;
      4'hD: g = 7'b0100001;
      4'hE: g = 7'b0000110;
      default: g = 7'b0001110;
    endcase
    return g;
  endfunction

  function automatic segVec_t wordGlyph(input logic [SEL_W-1:0] pos);
    segVec_t g;
    case (pos)
      2'd0: g = 7'b0001110;
      2'd1: g = 7'b0001000;
      2'd2: g = 7'b1111001;
      default: g = 7'b1000111;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/seg_tick_div.sv
module seg_tick_div #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] divCnt;

  assign tick = (divCnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        failFlag,
  output dispStrobe_t strobe
);
  logic [SEL_W-1:0] scanIdx;

  always_comb begin
    strobe.load     = tick;
    strobe.failMode = failFlag;
    strobe.digitSel = scanIdx;
  end

  // Fail mode advances the position; normal mode holds it at the
  // leftmost digit so the next entry into fail mode starts there.
  always_ff @(posedge clk) begin
    if (rst) begin
      scanIdx <= '0;
    end else if (tick) begin
      if (failFlag) begin
        scanIdx <= scanIdx + 1'b1;
      end else begin
        scanIdx <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_glyph_path.sv
module seg_glyph_path
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  dispStrobe_t       strobe,
  input  logic [3:0]        binIn,
  output segVec_t           segOut,
  output logic [DIGITS-1:0] digitEnN
);
  logic [DIGITS-1:0] scanEnN;
  logic [DIGITS-1:0] singleEnN;
  segVec_t           nextSeg;
  logic [DIGITS-1:0] nextEn;

  // Digit position 0 is the leftmost digit on the top enable bit.
  for (genvar i = 0; i < DIGITS; i++) begin : g_enDecode
    assign scanEnN[DIGITS-1-i]   = (strobe.digitSel != SEL_W'(i));
    assign singleEnN[DIGITS-1-i] = (i != 0);
  end

  always_comb begin
    if (strobe.failMode) begin
      nextSeg = wordGlyph(strobe.digitSel);
      nextEn  = scanEnN;
    end else begin
      nextSeg = hexGlyph(binIn);
      nextEn  = singleEnN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      segOut   <= SEG_BLANK;
      digitEnN <= '1;
    end else if (strobe.load) begin
      segOut   <= nextSeg;
      digitEnN <= nextEn;
    end
  end
endmodule

// File: rtl/seg_dual_display.sv
module seg_dual_display
  import seg_pkg::*;
#(
  parameter int TICK_DIV = 100000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       failFlag,
  input  logic [3:0] binIn,
  output logic [6:0] segOut,
  output logic [3:0] digitEnN
);
  logic        scanTick;
  dispStrobe_t strobe;

  seg_tick_div #(.TICK_DIV(TICK_DIV)) div_i (
    .clk  (clk),
    .rst  (rst),
    .tick (scanTick)
  );

  seg_scan_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (scanTick),
    .failFlag (failFlag),
    .strobe   (strobe)
  );

  seg_glyph_path path_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .binIn    (binIn),
    .segOut   (segOut),
    .digitEnN (digitEnN)
  );
endmodule

// File: rtl/seg_dual_display_chk.sv
module seg_dual_display_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       failFlag,
  input logic [6:0] segOut,
  input logic [3:0] digitEnN
);
  // R2
  stable_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(segOut) && $stable(digitEnN)));

  // R3
  normal_left_only_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !failFlag) |=> (digitEnN == 4'b0111));

  // R8
  one_digit_lit_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> ($countones(~digitEnN) == 1));

  // R5
  fail_letters_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && failFlag) |=> (segOut == 7'b0001110 || segOut == 7'b0001000 ||
                            segOut == 7'b1111001 || segOut == 7'b1000111));

  // R6
  scan_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && failFlag && digitEnN == 4'b1110) |=> (digitEnN == 4'b0111));
endmodule

bind seg_dual_display seg_dual_display_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .tick     (scanTick),
  .failFlag (failFlag),
  .segOut   (segOut),
  .digitEnN (digitEnN)
);

// File: tb/seg_dual_display_tb_top.sv
module seg_dual_display_tb_top;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       failFlag = 1'b0;
  logic [3:0] binIn = 4'h0;
  logic [6:0] segOut;
  logic [3:0] digitEnN;

  int vecCount = 0;
  int missCount = 0;
  int edgeCnt = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  logic [10:0] expQ[$];
  string       tagQ[$];

  // model state from the requirements
  int  mIdx = 0;
  logic [6:0] lastSeg = 7'h7F;
  logic [3:0] lastEn  = 4'hF;

  always #2 clk = ~clk;

  seg_dual_display #(.TICK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .failFlag(failFlag), .binIn(binIn),
    .segOut(segOut), .digitEnN(digitEnN)
  );

  function automatic logic [6:0] expHex(input logic [3:0] v);
    case (v)
      4'h0: return 7'b1000000;  4'h1: return 7'b1111001;
      4'h2: return 7'b0100100;  4'h3: return 7'b0110000;
      4'h4: return 7'b0011001;  4'h5: return 7'b0010010;
      4'h6: return 7'b0000010;  4'h7: return 7'b1111000;
      4'h8: return 7'b0000000;  4'h9: return 7'b0010000;
      4'hA: return 7'b0001000;  4'hB: return 7'b0000011;
      4'hC: return 7'b1000110;  4'hD: return 7'b0100001;
      4'hE: return 7'b0000110;  default: return 7'b0001110;
    endcase
  endfunction

  function automatic logic [6:0] expWord(input int p);
    case (p)
      0: return 7'b0001110;
      1: return 7'b0001000;
      2: return 7'b1111001;
      default: return 7'b1000111;
    endcase
  endfunction

  function automatic logic [3:0] expEn(input int p);
    case (p)
      0: return 4'b0111;
      1: return 4'b1011;
      2: return 4'b1101;
      default: return 4'b1110;
    endcase
  endfunction

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s seg/en actual=%b_%b expected=%b_%b", tag,
               act[10:4], act[3:0], exp[10:4], exp[3:0]);
    end
  endtask

  // driver: applies inputs for one tick period and queues the expected result
  task automatic doTick(input logic f, input logic [3:0] v, input string tag);
    failFlag = f;
    binIn = v;
    if (f) begin
      expQ.push_back({expWord(mIdx), expEn(mIdx)});
      mIdx = (mIdx + 1) % 4;
    end else begin
      expQ.push_back({expHex(v), 4'b0111});
      mIdx = 0;
    end
    tagQ.push_back(tag);
    repeat (DIV) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else edgeCnt <= edgeCnt + 1;
  end

  // monitor
  always @(negedge clk) begin
    if (running && !done) begin
      if (edgeCnt > 0 && (edgeCnt % DIV) == 0) begin
        if (expQ.size() > 0) begin
          logic [10:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, {segOut, digitEnN}, e);
          lastSeg = segOut;
          lastEn  = digitEnN;
        end
      end else if (edgeCnt > 0) begin
        // R2: nothing moves between tick edges
        check("R2", {segOut, digitEnN}, {lastSeg, lastEn});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: blank during reset
    check("R1", {segOut, digitEnN}, {7'h7F, 4'hF});
    rst = 1'b0;
    running = 1'b1;
    // R7: first fail-mode tick after reset shows F on leftmost digit
    doTick(1'b1, 4'h3, "R7");
    doTick(1'b1, 4'h3, "R5");
    doTick(1'b0, 4'h0, "R3");
    for (int i = 0; i < 16; i++) doTick(1'b0, 4'(i), "R4");
    for (int i = 0; i < 9; i++) doTick(1'b1, 4'h5, "R6");
    doTick(1'b0, 4'hA, "R4");
    doTick(1'b1, 4'h2, "R7");
    doTick(1'b1, 4'h2, "R5");
    doTick(1'b0, 4'h7, "R8");
    doTick(1'b1, 4'h9, "R7");
    doTick(1'b1, 4'h9, "R6");
    doTick(1'b1, 4'h9, "R6");
    doTick(1'b1, 4'h9, "R6");
    doTick(1'b1, 4'h9, "R6");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule